// File: doc/BRIEF.md
# Banked GPIO Controller with Edge-Triggered Interrupts

This block gives software control of several banks of 32 general-purpose pins through a small register port. The port is synchronous and moves one word per cycle. Each pin has a direction bit. A bit value of 1 makes the pin an input, and 0 makes it drive its output latch. Software changes output latch bits without a read-modify-write. It writes ones to a set word or to a clear word. The live pin level can be read back at any time, including when the pin is an output.

Every pin can watch for rising transitions, falling transitions or both, each enabled separately. The samples used for this pass through a two-flop synchronizer first. A detected edge sets a sticky status bit. The bit is cleared when software writes a one to it. Pins form interrupt groups of 16, and each group drives its own interrupt line. That line is the OR of the group's status bits, masked by a per-group enable bit held in one global word.

The block has no state machine. The edge pipeline and the write decode are its only sequencing.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every direction bit is 1, so `pin_oe` is all zeros. `pin_out`, all edge enables, all status bits and the group-enable word are zero. `irq` is zero.
- R2: Writing a bank's direction word (word 0) replaces its direction bits. `pin_oe` for that bank equals the inverse of those bits from the next clock. Reading the word returns them.
- R3: The output latch of a bank is changed in three ways. Word 1 replaces the whole latch. Word 2 sets the latch bits that are written as 1. Word 3 clears the latch bits that are written as 1. Bits written as 0 through word 2 or word 3 are unchanged. Reading words 1, 2 or 3 returns the latch, and `pin_out` follows the latch.
- R4: Reading word 4 returns the pin level of that bank after a two-flop synchronizer. A change on `pin_in` becomes visible after the second rising clock edge, whatever the direction. Writes to word 4 have no effect.
- R5: Rising enables are set by writing 1s to word 5 and cleared by writing 1s to word 6. Falling enables are set through word 7 and cleared through word 8. Reading either word of a pair returns that enable vector.
- R6: A pin whose synchronized level goes 0→1 with its rising enable on, or 1→0 with its falling enable on, sets its status bit (word 9). This happens on the third rising clock edge after the pin change. Transitions in a direction that is not enabled set nothing.
- R7: Status bits stay set until software writes 1 to them through word 9. Writing 0 leaves them unchanged. If a new edge and a clear of the same bit fall in the same cycle, the bit remains set.
- R8: The group-enable word sits at byte offset 0x08. Bit g enables group g, which covers global pins 16g to 16g+15, where bank b holds global pins 32b to 32b+31. `irq[g]` is the OR of the group's status bits ANDed with that enable bit, and it follows an enable write from the next clock.
- R9: Writes to unmapped or non-word-aligned offsets change nothing, and reads of them return zero. Only the low NGRP bits of the group-enable word are stored.
- R10: Bank b occupies ten consecutive words starting at byte offset 0x10 + 0x28·b. The words are in the order direction, output, set, clear, input, set-rising, clear-rising, set-falling, clear-falling, status. Banks operate independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_BANKS·32 | Pin levels from the pads |
| pin_out | output | NUM_BANKS·32 | Output latch values |
| pin_oe | output | NUM_BANKS·32 | Output enables, inverse of the direction bits |
| irq | output | NUM_BANKS·2 | One interrupt line per 16-pin group |

## Verification
Each result has a fixed latency:
- Register writes take effect at the edge that samples `reg_wr`, so latch, direction and enable values are checked one cycle after the write.
- Reads are combinational and are sampled shortly after the address is driven on a falling edge.
- The input word changes after the second rising edge following a pin change. The bench samples it after the first edge, expecting the old value, and after the second, expecting the new one.
- Status and `irq` appear after the third edge. The bench checks that they are still low after two edges and high after three. It places a clear write exactly on that third edge to show that the set wins.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int WORD_W      = 32;
    localparam int GROUP_PINS  = 16;
    localparam int BANK_BASE   = 16;   // 0x10
    localparam int BANK_STRIDE = 40;   // 0x28, ten words
    localparam int GRP_EN_OFS  = 8;    // 0x08

    typedef enum logic [3:0] {
        W_DIR   = 4'd0,
        W_OUT   = 4'd1,
        W_SET   = 4'd2,
        W_CLR   = 4'd3,
        W_IN    = 4'd4,
        W_SRISE = 4'd5,
        W_CRISE = 4'd6,
        W_SFALL = 4'd7,
        W_CFALL = 4'd8,
        W_STAT  = 4'd9
    } bank_word_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] level,
    output logic [W-1:0] edge_hit
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level    = sync_q;
    assign edge_hit = (sync_q & ~prev_q & rise_en) | (~sync_q & prev_q & fall_en);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  bank_word_e        word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] pin_in,
    output logic [WORD_W-1:0] pin_out,
    output logic [WORD_W-1:0] pin_oe,
    output logic [WORD_W-1:0] status
);
    logic [WORD_W-1:0] dir_q;
    logic [WORD_W-1:0] out_q;
    logic [WORD_W-1:0] rise_q;
    logic [WORD_W-1:0] fall_q;
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] level;
    logic [WORD_W-1:0] edge_hit;
    logic [WORD_W-1:0] stat_clr;
    logic              do_wr;

    gpio_sync_edge #(.W(WORD_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .level    (level),
        .edge_hit (edge_hit)
    );

    assign do_wr    = sel && wr;
    assign stat_clr = (do_wr && word == W_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | edge_hit;
            if (do_wr) begin
                case (word)
                    W_DIR:   dir_q  <= wdata;
                    W_OUT:   out_q  <= wdata;
                    W_SET:   out_q  <= out_q | wdata;
                    W_CLR:   out_q  <= out_q & ~wdata;
                    W_SRISE: rise_q <= rise_q | wdata;
                    W_CRISE: rise_q <= rise_q & ~wdata;
                    W_SFALL: fall_q <= fall_q | wdata;
                    W_CFALL: fall_q <= fall_q & ~wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (word)
                W_DIR:                  rdata = dir_q;
                W_OUT, W_SET, W_CLR:    rdata = out_q;
                W_IN:                   rdata = level;
                W_SRISE, W_CRISE:       rdata = rise_q;
                W_SFALL, W_CFALL:       rdata = fall_q;
                W_STAT:                 rdata = stat_q;
                default:                rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
    assign status  = stat_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    localparam int NPIN     = NUM_BANKS * WORD_W,
    localparam int NGRP     = NPIN / GROUP_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NGRP-1:0]   irq
);
    logic [NGRP-1:0]   grp_en_q;
    logic [NPIN-1:0]   stat_all;
    logic [WORD_W-1:0] bank_rd [NUM_BANKS];
    logic              grp_hit;

    assign grp_hit = (reg_addr == ADDR_W'(GRP_EN_OFS));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BASE = BANK_BASE + BANK_STRIDE * b;
        logic [ADDR_W-1:0] rel;
        logic              hit;
        bank_word_e        word;

        assign rel  = reg_addr - ADDR_W'(BASE);
        assign hit  = (reg_addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(BANK_STRIDE))
                      && (rel[1:0] == 2'b00);
        assign word = bank_word_e'(rel[5:2]);

        gpio_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (hit),
            .wr      (reg_wr),
            .word    (word),
            .wdata   (reg_wdata),
            .rdata   (bank_rd[b]),
            .pin_in  (pin_in[b*WORD_W +: WORD_W]),
            .pin_out (pin_out[b*WORD_W +: WORD_W]),
            .pin_oe  (pin_oe[b*WORD_W +: WORD_W]),
            .status  (stat_all[b*WORD_W +: WORD_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_en_q <= '0;
        end else if (reg_wr && grp_hit) begin
            grp_en_q <= reg_wdata[NGRP-1:0];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_irq
        assign irq[g] = grp_en_q[g] && (|stat_all[g*GROUP_PINS +: GROUP_PINS]);
    end

    always_comb begin
        reg_rdata = grp_hit ? WORD_W'(grp_en_q) : '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            reg_rdata = reg_rdata | bank_rd[b];
        end
    end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    localparam int NPIN     = NUM_BANKS * WORD_W,
    localparam int NGRP     = NPIN / GROUP_PINS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic [NGRP-1:0]   irq
);
    localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(BANK_BASE + 4 * 0);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BANK_BASE + 4 * 2);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BANK_BASE + 4 * 3);
    localparam logic [ADDR_W-1:0] A_GRP  = ADDR_W'(GRP_EN_OFS);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0 && pin_oe == '0 && pin_out == '0));

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIR0) |=> pin_oe[WORD_W-1:0] == ~$past(reg_wdata));

    // R3
    set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET0) |=>
            pin_out[WORD_W-1:0] == ($past(pin_out[WORD_W-1:0]) | $past(reg_wdata)));

    // R3
    clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR0) |=>
            pin_out[WORD_W-1:0] == ($past(pin_out[WORD_W-1:0]) & ~$past(reg_wdata)));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_GRP && reg_wdata[NGRP-1:0] == '0) |=> irq == '0);

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
    localparam int NB   = 2;
    localparam int NPIN = NB * 32;
    localparam int NGRP = NB * 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out;
    logic [NPIN-1:0] pin_oe;
    logic [NGRP-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;

    gpio_edge_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #4 clk = ~clk;

    // kind: 0 write, 1 read compare, 2 pin_out[31:0] compare, 3 pin_oe[31:0] compare
    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd2,  8'h10, 32'hFFFF0000},  // R2 direction write
        '{2'd1, 4'd2,  8'h10, 32'hFFFF0000},
        '{2'd3, 4'd2,  8'h00, 32'h0000FFFF},
        '{2'd0, 4'd3,  8'h14, 32'h000000F0},  // R3 latch write
        '{2'd1, 4'd3,  8'h18, 32'h000000F0},
        '{2'd0, 4'd3,  8'h18, 32'h0000000F},
        '{2'd1, 4'd3,  8'h14, 32'h000000FF},
        '{2'd0, 4'd3,  8'h1C, 32'h00000030},
        '{2'd1, 4'd3,  8'h1C, 32'h000000CF},
        '{2'd2, 4'd3,  8'h00, 32'h000000CF},
        '{2'd0, 4'd10, 8'h40, 32'hA5A50000},  // R10 bank 1 map
        '{2'd1, 4'd10, 8'h3C, 32'hA5A50000},
        '{2'd1, 4'd10, 8'h14, 32'h000000CF},
        '{2'd0, 4'd5,  8'h24, 32'h00000101},  // R5 enables
        '{2'd0, 4'd5,  8'h24, 32'h00000010},
        '{2'd1, 4'd5,  8'h28, 32'h00000111},
        '{2'd0, 4'd5,  8'h28, 32'h00000001},
        '{2'd1, 4'd5,  8'h24, 32'h00000110},
        '{2'd0, 4'd5,  8'h2C, 32'h80000000},
        '{2'd1, 4'd5,  8'h30, 32'h80000000},
        '{2'd0, 4'd9,  8'h60, 32'hFFFFFFFF},  // R9 unmapped
        '{2'd1, 4'd9,  8'h60, 32'h00000000},
        '{2'd0, 4'd9,  8'h00, 32'hFFFFFFFF},
        '{2'd1, 4'd9,  8'h00, 32'h00000000},
        '{2'd1, 4'd9,  8'h0C, 32'h00000000},
        '{2'd0, 4'd9,  8'h20, 32'hFFFFFFFF},
        '{2'd1, 4'd9,  8'h20, 32'h00000000},
        '{2'd1, 4'd9,  8'h16, 32'h00000000},
        '{2'd2, 4'd9,  8'h00, 32'h000000CF},
        '{2'd0, 4'd8,  8'h08, 32'hFFFFFFFF},  // R8 group enable width
        '{2'd1, 4'd8,  8'h08, 32'h0000000F},
        '{2'd0, 4'd8,  8'h08, 32'h00000000},
        '{2'd0, 4'd5,  8'h28, 32'hFFFFFFFF},
        '{2'd0, 4'd5,  8'h30, 32'hFFFFFFFF},
        '{2'd0, 4'd2,  8'h10, 32'hFFFFFFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32], 32'h0);
        check("R1 pin_out", pin_out[31:0] | pin_out[63:32], 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(8'h10, v); check("R1 dir", v, 32'hFFFFFFFF);
        rd(8'h5C, v); check("R1 status", v, 32'h0);
        rd(8'h08, v); check("R1 group enable", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].kind)
                2'd0: wr(VECS[i].addr, VECS[i].data);
                2'd1: begin
                    rd(VECS[i].addr, v);
                    check($sformatf("R%0d vec %0d read %02h", VECS[i].req, i, VECS[i].addr), v, VECS[i].data);
                end
                2'd2: begin
                    @(negedge clk); #1;
                    check($sformatf("R%0d vec %0d pin_out", VECS[i].req, i), pin_out[31:0], VECS[i].data);
                end
                default: begin
                    @(negedge clk); #1;
                    check($sformatf("R%0d vec %0d pin_oe", VECS[i].req, i), pin_oe[31:0], VECS[i].data);
                end
            endcase
        end

        // R4 input read, bank 1 configured as outputs
        wr(8'h38, 32'h0);
        @(negedge clk);
        reg_addr = 8'h48;
        pin_in[63:32] = 32'h1234ABCD;
        wait_edges(1);
        check("R4 input after one edge", reg_rdata, 32'h0);
        wait_edges(1);
        check("R4 input after two edges", reg_rdata, 32'h1234ABCD);
        wr(8'h48, 32'h0);
        rd(8'h48, v); check("R4 input write ignored", v, 32'h1234ABCD);

        // R6 rising edge on pin 3, status and irq on the third edge
        wr(8'h24, 32'h8);
        wr(8'h08, 32'h1);
        @(negedge clk);
        reg_addr = 8'h34;
        pin_in[3] = 1'b1;
        wait_edges(2);
        check("R6 status before third edge", reg_rdata, 32'h0);
        check("R6 irq before third edge", 32'(irq), 32'h0);
        wait_edges(1);
        check("R6 status on third edge", reg_rdata, 32'h8);
        check("R6 irq on third edge", 32'(irq), 32'h1);

        // R7 sticky, write-one-to-clear
        wr(8'h34, 32'h0);
        rd(8'h34, v); check("R7 zero write keeps status", v, 32'h8);
        wr(8'h34, 32'h8);
        rd(8'h34, v); check("R7 one write clears status", v, 32'h0);
        check("R7 irq drops after clear", 32'(irq), 32'h0);

        // R6 falling edge on pin 3 not enabled
        @(negedge clk);
        pin_in[3] = 1'b0;
        wait_edges(5);
        rd(8'h34, v); check("R6 disabled falling edge ignored", v, 32'h0);

        // R6 both edges on pin 20, group 1
        wr(8'h24, 32'h00100000);
        wr(8'h2C, 32'h00100000);
        wr(8'h08, 32'h2);
        @(negedge clk); pin_in[20] = 1'b1;
        wait_edges(4);
        rd(8'h34, v); check("R6 both-edge rise", v, 32'h00100000);
        check("R8 group 1 irq", 32'(irq), 32'h2);
        wr(8'h34, 32'h00100000);
        @(negedge clk); pin_in[20] = 1'b0;
        wait_edges(4);
        rd(8'h34, v); check("R6 both-edge fall", v, 32'h00100000);
        wr(8'h34, 32'h00100000);

        // R8 gating by group enable
        wr(8'h08, 32'h0);
        @(negedge clk); pin_in[20] = 1'b1;
        wait_edges(4);
        check("R8 irq masked", 32'(irq), 32'h0);
        rd(8'h34, v); check("R8 status recorded while masked", v, 32'h00100000);
        wr(8'h08, 32'h2);
        #1;
        check("R8 irq after enable", 32'(irq), 32'h2);
        wr(8'h34, 32'h00100000);

        // R7 edge and clear in the same cycle: set wins
        @(negedge clk); pin_in[20] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_addr = 8'h34; reg_wdata = 32'h00100000; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        rd(8'h34, v); check("R7 set wins over clear", v, 32'h00100000);

        // R10 bank 1 edge drives group 2
        wr(8'h4C, 32'h2);
        wr(8'h08, 32'h4);
        @(negedge clk); pin_in[33] = 1'b1;
        wait_edges(4);
        rd(8'h5C, v); check("R10 bank 1 status", v, 32'h2);
        check("R10 bank 1 irq group 2", 32'(irq), 32'h4);
        rd(8'h34, v); check("R10 bank 0 status independent", v, 32'h00100000);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 reset clears pin_out", pin_out[31:0] | pin_out[63:32], 32'h0);
        check("R1 reset clears irq", 32'(irq), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h3C, v); check("R1 reset clears bank 1 latch", v, 32'h0);

        finish_run();
    end
endmodule